// File: doc/BRIEF.md
# ADC conversion sequencer controller

This block holds the control and status logic for a multi-channel analog-to-digital converter. Software reaches it through a small register port with a write strobe and a read strobe. On the other side it talks to an external conversion core through a four-signal handshake: a channel number, a one-cycle start pulse, a done pulse, and a raw 12-bit result. The block owns the power-up and power-down sequencing of the converter, the command bits that launch and stop work, the set of channels that takes part, and the run mode.

Once started, the block walks the selected channels from the lowest index to the highest. It can run one pass (single), repeat passes until stopped (continuous), or convert one channel per start command (stepped). Each result is cut down to the chosen resolution and justified right or left in a 16-bit data field. The block then raises the per-result and end-of-pass flags, and flags an overrun when a new result overwrites one that was never read.

Registers: STAT at address 0 (bit0 ready, bit1 result-ready, bit2 pass-done, bit3 overrun, all write-1-to-clear). CTRL at address 1 (bit0 enable, bit1 disable, bit2 start, bit3 stop). CFG at address 2 (bits1:0 resolution, bit2 left-justify, bit3 continuous, bit4 stepped). MASK at address 3 (bit n selects channel n). DATA at address 4. A read returns its value in `rdata` on the clock edge that samples `rd_en`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0. Writing CTRL bit0 = 1 while off sets enable at once. STAT bit0 (ready) rises exactly READY_DLY cycles later, and writing 1 to STAT bit0 clears it.
- R2: A disable request (CTRL bit1) is taken only while enable is 1 and start is 0. While the shutdown runs, disable reads back 1. After OFF_DLY cycles, enable and disable both read 0. A disable request made while start is 1 has no effect.
- R3: A start request (CTRL bit2) is taken only when the block is ready and idle, with no disable pending and no disable in the same write. Otherwise it has no effect.
- R4: Each conversion is launched by a one-cycle `core_start` pulse, with `core_chan` naming a channel whose MASK bit is set. Channels are taken in ascending index order.
- R5: In single mode (CFG bit3 = 0, bit4 = 0), start converts every selected channel once. It clears in the same cycle as pass-done (STAT bit2) is raised.
- R6: In stepped mode (CFG bit4 = 1), each start converts only the next selected channel and then clears. Pass-done rises after the highest selected channel, and the next start wraps to the lowest.
- R7: In continuous mode (CFG bit3 = 1), passes repeat until a stop request (CTRL bit3). The stop waits for any conversion in flight. Start and stop then clear together, and no further conversion is launched.
- R8: Writes to MASK or CFG are ignored while start is 1. A CFG write that sets both bit3 and bit4 is ignored.
- R9: A start with an all-zero MASK launches nothing. Start clears on the next cycle, together with a rising pass-done.
- R10: For resolution code 00/01/10/11 (12/10/8/6 bits), the raw result loses its 0/2/4/6 least significant bits. It is then right-justified (CFG bit2 = 0) or left-justified into 16 bits (CFG bit2 = 1). All unused bits read 0.
- R11: Result-ready (STAT bit1) is set with every result. It is cleared by writing 1 to it or by reading DATA. A result arriving in the same cycle as the clear leaves it set.
- R12: Overrun (STAT bit3) is set when a result arrives while result-ready is still 1. Writing 1 to it clears it, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Registered read data |
| core_chan | output | CH_W | Channel to convert |
| core_start | output | 1 | One-cycle conversion launch |
| core_done | input | 1 | Conversion complete pulse |
| core_result | input | RAW_W | Raw conversion result |

## Verification
The hardest case to reach from the ports is a write-1-to-clear of result-ready and overrun that lands in the very cycle a new result arrives. The bench's converter model has a fixed latency. From that latency the bench counts register stages from the start write to the done pulse, and places the clear write on that edge. A second hard case is the stepped-mode cursor carrying across separate start commands and wrapping after the highest channel. The bench reaches it by issuing three starts on a two-channel mask. It logs every launched channel in its converter model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_IDLE = 3'd2,
    ST_CONV = 3'd3,
    ST_SHUT = 3'd4
  } seq_state_t;

  localparam int A_STAT = 0;
  localparam int A_CTRL = 1;
  localparam int A_CFG  = 2;
  localparam int A_MASK = 3;
  localparam int A_DATA = 4;

  // STAT fields
  localparam int B_RDY = 0;
  localparam int B_EOC = 1;
  localparam int B_EOS = 2;
  localparam int B_OVR = 3;
  // CTRL fields
  localparam int B_EN   = 0;
  localparam int B_DIS  = 1;
  localparam int B_GO   = 2;
  localparam int B_HALT = 3;
  // CFG fields
  localparam int B_RES0 = 0;
  localparam int B_LEFT = 2;
  localparam int B_CONT = 3;
  localparam int B_STEP = 4;
endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int NUM_CH = 18,
  parameter int CH_W   = 5
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   from,
  output logic [CH_W-1:0]   idx,
  output logic              last
);
  // lowest selected channel at or above the cursor
  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) idx = CH_W'(i);
    end
  end

  // no selected channel above the picked one
  always_comb begin
    last = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (mask[i] && (i > int'(idx))) last = 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
  parameter int RAW_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic [1:0]        res,
  input  logic              left,
  output logic [DATA_W-1:0] out
);
  localparam int PAD = DATA_W - RAW_W;

  logic [4:0]        drop;
  logic [DATA_W-1:0] ext;
  logic [DATA_W-1:0] kept;

  always_comb begin
    drop = {2'b00, res, 1'b0};
    ext  = DATA_W'(raw);
    kept = ext >> drop;
    out  = left ? (kept << (5'(PAD) + drop)) : kept;
  end
endmodule

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd
  import adc_seq_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int READY_DLY = 4,
  parameter int OFF_DLY   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_wr,
  input  logic            req_en,
  input  logic            req_dis,
  input  logic            req_go,
  input  logic            req_halt,
  input  logic            mode_cont,
  input  logic            mode_step,
  input  logic            mask_any,
  input  logic            cur_rst,
  input  logic [CH_W-1:0] pick_idx,
  input  logic            pick_last,
  input  logic            core_done,
  output seq_state_t      state,
  output logic            en,
  output logic            dis,
  output logic            go,
  output logic            halt,
  output logic            core_start,
  output logic [CH_W-1:0] core_chan,
  output logic [CH_W-1:0] cursor,
  output logic            done_evt,
  output logic            eos_evt,
  output logic            ready_evt
);
  localparam int CNT_MAX = (READY_DLY > OFF_DLY) ? READY_DLY : OFF_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic en_acc, dis_acc, go_acc, halt_acc, idle_go;

  always_comb begin
    en_acc    = ctrl_wr && req_en && (state == ST_OFF);
    dis_acc   = ctrl_wr && req_dis && en && !dis && !go &&
                ((state == ST_IDLE) || (state == ST_WAKE));
    go_acc    = ctrl_wr && req_go && (state == ST_IDLE) && !go && !dis_acc;
    halt_acc  = ctrl_wr && req_halt && go && !halt;
    idle_go   = (state == ST_IDLE) && go && !halt;
    done_evt  = (state == ST_CONV) && core_done;
    eos_evt   = (idle_go && !mask_any) || (done_evt && pick_last);
    ready_evt = (state == ST_WAKE) && !dis_acc && (cnt == CNT_W'(READY_DLY - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      en         <= 1'b0;
      dis        <= 1'b0;
      go         <= 1'b0;
      halt       <= 1'b0;
      core_start <= 1'b0;
      core_chan  <= '0;
      cursor     <= '0;
      cnt        <= '0;
    end else begin
      core_start <= 1'b0;
      if (halt_acc) halt <= 1'b1;
      if (cur_rst) cursor <= '0;
      case (state)
        ST_OFF: begin
          if (en_acc) begin
            en    <= 1'b1;
            state <= ST_WAKE;
            cnt   <= '0;
          end
        end
        ST_WAKE: begin
          if (dis_acc) begin
            dis   <= 1'b1;
            state <= ST_SHUT;
            cnt   <= '0;
          end else if (ready_evt) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (dis_acc) begin
            dis   <= 1'b1;
            state <= ST_SHUT;
            cnt   <= '0;
          end else if (go_acc) begin
            go <= 1'b1;
          end else if (go && halt) begin
            go     <= 1'b0;
            halt   <= 1'b0;
            cursor <= '0;
          end else if (go) begin
            if (!mask_any) begin
              go   <= 1'b0;
              halt <= 1'b0;
            end else begin
              state      <= ST_CONV;
              core_start <= 1'b1;
              core_chan  <= pick_idx;
            end
          end
        end
        ST_CONV: begin
          if (core_done) begin
            state  <= ST_IDLE;
            cursor <= pick_last ? '0 : pick_idx + 1'b1;
            if (halt) begin
              go     <= 1'b0;
              halt   <= 1'b0;
              cursor <= '0;
            end else if (mode_step || (!mode_cont && pick_last)) begin
              go   <= 1'b0;
              halt <= 1'b0;
            end
          end
        end
        ST_SHUT: begin
          if (cnt == CNT_W'(OFF_DLY - 1)) begin
            state <= ST_OFF;
            en    <= 1'b0;
            dis   <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 18,
  parameter int RAW_W     = 12,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int REG_W     = 32,
  parameter int READY_DLY = 4,
  parameter int OFF_DLY   = 2,
  parameter int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [CH_W-1:0]   core_chan,
  output logic              core_start,
  input  logic              core_done,
  input  logic [RAW_W-1:0]  core_result
);
  logic [1:0]        cfg_res;
  logic              cfg_left, cfg_cont, cfg_step;
  logic [NUM_CH-1:0] mask_q;
  logic [DATA_W-1:0] data_q, fmt_out;
  logic              fl_rdy, fl_eoc, fl_eos, fl_ovr;

  seq_state_t        seq_state;
  logic              en, dis, go, halt;
  logic [CH_W-1:0]   cursor, pick_idx;
  logic              pick_last, done_evt, eos_evt, ready_evt;

  logic ctrl_wr, stat_wr, cfg_ok, mask_ok, data_rd;
  logic [REG_W-1:0] rd_mux;
  logic unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:NUM_CH];

  always_comb begin
    ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
    stat_wr = wr_en && (addr == ADDR_W'(A_STAT));
    cfg_ok  = wr_en && (addr == ADDR_W'(A_CFG)) && !go &&
              !(wdata[B_CONT] && wdata[B_STEP]);
    mask_ok = wr_en && (addr == ADDR_W'(A_MASK)) && !go;
    data_rd = rd_en && (addr == ADDR_W'(A_DATA));
  end

  adc_seq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask (mask_q),
    .from (cursor),
    .idx  (pick_idx),
    .last (pick_last)
  );

  adc_seq_fmt #(.RAW_W(RAW_W), .DATA_W(DATA_W)) u_fmt (
    .raw  (core_result),
    .res  (cfg_res),
    .left (cfg_left),
    .out  (fmt_out)
  );

  adc_seq_cmd #(.CH_W(CH_W), .READY_DLY(READY_DLY), .OFF_DLY(OFF_DLY)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .req_en     (wdata[B_EN]),
    .req_dis    (wdata[B_DIS]),
    .req_go     (wdata[B_GO]),
    .req_halt   (wdata[B_HALT]),
    .mode_cont  (cfg_cont),
    .mode_step  (cfg_step),
    .mask_any   (|mask_q),
    .cur_rst    (cfg_ok || mask_ok),
    .pick_idx   (pick_idx),
    .pick_last  (pick_last),
    .core_done  (core_done),
    .state      (seq_state),
    .en         (en),
    .dis        (dis),
    .go         (go),
    .halt       (halt),
    .core_start (core_start),
    .core_chan  (core_chan),
    .cursor     (cursor),
    .done_evt   (done_evt),
    .eos_evt    (eos_evt),
    .ready_evt  (ready_evt)
  );

  // configuration and channel set
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_res  <= '0;
      cfg_left <= 1'b0;
      cfg_cont <= 1'b0;
      cfg_step <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (cfg_ok) begin
        cfg_res  <= wdata[B_RES0 +: 2];
        cfg_left <= wdata[B_LEFT];
        cfg_cont <= wdata[B_CONT];
        cfg_step <= wdata[B_STEP];
      end
      if (mask_ok) mask_q <= wdata[NUM_CH-1:0];
    end
  end

  // status flags: a hardware set beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_rdy <= 1'b0;
      fl_eoc <= 1'b0;
      fl_eos <= 1'b0;
      fl_ovr <= 1'b0;
      data_q <= '0;
    end else begin
      if (ready_evt)                         fl_rdy <= 1'b1;
      else if (stat_wr && wdata[B_RDY])      fl_rdy <= 1'b0;

      if (done_evt)                          fl_eoc <= 1'b1;
      else if ((stat_wr && wdata[B_EOC]) || data_rd) fl_eoc <= 1'b0;

      if (eos_evt)                           fl_eos <= 1'b1;
      else if (stat_wr && wdata[B_EOS])      fl_eos <= 1'b0;

      if (done_evt && fl_eoc)                fl_ovr <= 1'b1;
      else if (stat_wr && wdata[B_OVR])      fl_ovr <= 1'b0;

      if (done_evt) data_q <= fmt_out;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_STAT): begin
        rd_mux[B_RDY] = fl_rdy;
        rd_mux[B_EOC] = fl_eoc;
        rd_mux[B_EOS] = fl_eos;
        rd_mux[B_OVR] = fl_ovr;
      end
      ADDR_W'(A_CTRL): begin
        rd_mux[B_EN]   = en;
        rd_mux[B_DIS]  = dis;
        rd_mux[B_GO]   = go;
        rd_mux[B_HALT] = halt;
      end
      ADDR_W'(A_CFG): begin
        rd_mux[B_RES0 +: 2] = cfg_res;
        rd_mux[B_LEFT]      = cfg_left;
        rd_mux[B_CONT]      = cfg_cont;
        rd_mux[B_STEP]      = cfg_step;
      end
      ADDR_W'(A_MASK): rd_mux[NUM_CH-1:0] = mask_q;
      ADDR_W'(A_DATA): rd_mux[DATA_W-1:0] = data_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input seq_state_t        state,
  input logic              en,
  input logic              dis,
  input logic              go,
  input logic              halt,
  input logic              core_start,
  input logic [CH_W-1:0]   core_chan,
  input logic              core_done,
  input logic [NUM_CH-1:0] mask_q,
  input logic              fl_eoc,
  input logic              fl_ovr,
  input logic              cfg_cont,
  input logic              cfg_step
);
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  a_r4_chan_selected: assert property (@(posedge clk) disable iff (rst)
    core_start |-> mask_q[core_chan]);

  a_r3_go_needs_en: assert property (@(posedge clk) disable iff (rst)
    go |-> (en && !dis));

  a_r2_dis_needs_en: assert property (@(posedge clk) disable iff (rst)
    dis |-> en);

  a_r7_halt_needs_go: assert property (@(posedge clk) disable iff (rst)
    halt |-> go);

  a_r8_mask_frozen: assert property (@(posedge clk) disable iff (rst)
    (go && $past(go)) |-> $stable(mask_q));

  a_r8_no_dual_mode: assert property (@(posedge clk) disable iff (rst)
    !(cfg_cont && cfg_step));

  a_r11_eoc_on_result: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && core_done) |=> fl_eoc);

  a_r12_ovr_on_overlap: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && core_done && fl_eoc) |=> fl_ovr);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state      (seq_state),
  .en         (en),
  .dis        (dis),
  .go         (go),
  .halt       (halt),
  .core_start (core_start),
  .core_chan  (core_chan),
  .core_done  (core_done),
  .mask_q     (mask_q),
  .fl_eoc     (fl_eoc),
  .fl_ovr     (fl_ovr),
  .cfg_cont   (cfg_cont),
  .cfg_step   (cfg_step)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int READY_DLY  = 4;
  localparam int OFF_DLY    = 2;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  core_chan;
  logic        core_start;
  logic        core_done = 1'b0;
  logic [11:0] core_result = '0;

  logic [11:0] raw_val = 12'hABC;
  int          log_ch [0:255];
  int          log_n = 0;
  int          dly = 0;
  int          checks = 0, failures = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.READY_DLY(READY_DLY), .OFF_DLY(OFF_DLY)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .core_chan(core_chan),
    .core_start(core_start), .core_done(core_done), .core_result(core_result)
  );

  // converter model with fixed latency; logs launched channels
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      dly <= LAT;
      if (log_n < 256) log_ch[log_n] <= int'(core_chan);
      log_n <= log_n + 1;
    end else if (dly != 0) begin
      if (dly == 1) begin
        core_done   <= 1'b1;
        core_result <= raw_val;
      end
      dly <= dly - 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_go_clear(input string tag);
    logic [31:0] t;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, t);
      if (t[2] == 1'b0) return;
    end
    failures++;
    $display("FAIL %s start never cleared actual=1 expected=0", tag);
  endtask

  function automatic logic [15:0] fexp(input logic [11:0] raw, input int res, input bit left);
    logic [15:0] t;
    t = 16'(raw) >> (2 * res);
    return left ? 16'(t << (4 + 2 * res)) : t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R4 reset core_start", {31'b0, core_start}, 32'h0);

    // R3 start while off is ignored
    wr(3'd1, 32'h4);
    rd(3'd1, v);
    check("R3 start while off", v, 32'h0);

    // R1 enable and ready latency
    wr(3'd1, 32'h1);
    for (int i = 1; i <= READY_DLY + 1; i++) begin
      rd(3'd0, v);
      check("R1 ready timing", {31'b0, v[0]}, {31'b0, (i > READY_DLY)});
    end
    rd(3'd1, v);
    check("R1 enable bit", v, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    check("R1 ready w1c", v, 32'h0);

    // R8 both run modes rejected
    wr(3'd2, 32'h18);
    rd(3'd2, v);
    check("R8 dual mode rejected", v, 32'h0);

    // R9 empty mask
    s = log_n;
    wr(3'd1, 32'h4);
    idle(2);
    rd(3'd1, v);
    check("R9 start cleared", v, 32'h1);
    rd(3'd0, v);
    check("R9 pass-done set", v, 32'h4);
    check("R9 nothing launched", 32'(log_n), 32'(s));
    wr(3'd0, 32'h4);

    // R5 / R4 single pass over channels 1, 5, 17
    wr(3'd3, 32'h20022);
    s = log_n;
    wr(3'd1, 32'h4);
    wait_go_clear("R5");
    check("R5 count", 32'(log_n - s), 32'd3);
    check("R4 order 0", 32'(log_ch[s]), 32'd1);
    check("R4 order 1", 32'(log_ch[s+1]), 32'd5);
    check("R4 order 2", 32'(log_ch[s+2]), 32'd17);
    rd(3'd0, v);
    check("R12 overrun after unread results", v, 32'hE);

    // R12 w1c of overrun leaves result-ready
    wr(3'd0, 32'h8);
    rd(3'd0, v);
    check("R12 overrun w1c", v, 32'h6);

    // R11/R12 clear colliding with a result: set wins
    wr(3'd3, 32'h200);
    wr(3'd0, 32'h4);
    wr(3'd1, 32'h4);
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    wr(3'd0, 32'hA);
    rd(3'd0, v);
    check("R11 set beats clear", {31'b0, v[1]}, 32'h1);
    check("R12 set beats clear", {31'b0, v[3]}, 32'h1);
    wait_go_clear("R11");
    rd(3'd4, v);
    check("R10 default format", v, 32'(fexp(raw_val, 0, 1'b0)));
    rd(3'd0, v);
    check("R11 cleared by data read", {31'b0, v[1]}, 32'h0);

    // R11 w1c
    wr(3'd0, 32'hF);
    wr(3'd1, 32'h4);
    wait_go_clear("R11b");
    wr(3'd0, 32'h2);
    rd(3'd0, v);
    check("R11 w1c", {31'b0, v[1]}, 32'h0);

    // R6 stepped mode on channels 2, 3
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h0C);
    wr(3'd0, 32'hF);
    s = log_n;
    wr(3'd1, 32'h4);
    wait_go_clear("R6a");
    rd(3'd0, v);
    check("R6 step one result", v[2:1], 2'b01);
    wr(3'd1, 32'h4);
    wait_go_clear("R6b");
    rd(3'd0, v);
    check("R6 step pass-done", {31'b0, v[2]}, 32'h1);
    wr(3'd1, 32'h4);
    wait_go_clear("R6c");
    check("R6 count", 32'(log_n - s), 32'd3);
    check("R6 first", 32'(log_ch[s]), 32'd2);
    check("R6 second", 32'(log_ch[s+1]), 32'd3);
    check("R6 wrap", 32'(log_ch[s+2]), 32'd2);

    // R7 continuous on channels 0, 4
    wr(3'd2, 32'h08);
    wr(3'd3, 32'h11);
    s = log_n;
    wr(3'd1, 32'h4);
    for (int i = 0; i < 2000 && log_n < s + 5; i++) @(negedge clk);
    // R8 writes ignored while running; R2 disable ignored while running
    wr(3'd3, 32'hFF);
    wr(3'd2, 32'h00);
    wr(3'd1, 32'h2);
    rd(3'd3, v);
    check("R8 mask frozen", v, 32'h11);
    rd(3'd2, v);
    check("R8 cfg frozen", v, 32'h08);
    rd(3'd1, v);
    check("R2 disable ignored while running", v, 32'h5);
    wr(3'd1, 32'h8);
    wait_go_clear("R7");
    rd(3'd1, v);
    check("R7 start and stop cleared", v, 32'h1);
    check("R7 passes repeated", 32'(log_n - s >= 5), 32'h1);
    for (int k = s; k < log_n; k++)
      check("R7 order", 32'(log_ch[k]), ((k - s) % 2 == 0) ? 32'd0 : 32'd4);
    s = log_n;
    idle(20);
    check("R7 no launch after stop", 32'(log_n), 32'(s));

    // R10 format sweep on channel 7
    wr(3'd3, 32'h80);
    for (int res = 0; res < 4; res++) begin
      for (int al = 0; al < 2; al++) begin
        for (int r = 0; r < 4; r++) begin
          raw_val = (r == 0) ? 12'hFFF : (r == 1) ? 12'hA5C : (r == 2) ? 12'h001 : 12'h7E3;
          wr(3'd2, 32'(res) | (32'(al) << 2));
          wr(3'd1, 32'h4);
          wait_go_clear("R10");
          rd(3'd4, v);
          check("R10 format", v, 32'(fexp(raw_val, res, al[0])));
        end
      end
    end

    // R3 start in same write as disable is dropped; R2 shutdown
    wr(3'd1, 32'h6);
    rd(3'd1, v);
    check("R2 disable pending", v, 32'h3);
    idle(OFF_DLY + 2);
    rd(3'd1, v);
    check("R2 off state", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule